// File: doc/BRIEF.md
# Center-Aligned Timer Counter with Preloaded Reload

This block is the counting core of a general-purpose timer. A clock divider turns the system clock into a counting tick once every N+1 clocks. The counter steps on that tick in one of two modes. In down mode it counts toward zero and then reloads. In center-aligned mode it climbs from zero toward the reload value, turns around, and falls back to zero. Each turnaround raises an update event, which also sets a sticky interrupt flag.

The reload value and the divide value are written into preload registers. They reach the working (shadow) copies only on an update event, so software can change them without disturbing the period that is in progress. Software can suppress update events with a control bit. It can also force an update event at any time. A forced update restarts both the counter and the divider from zero.

Top module: `ctr_center_timer`

## Requirements
- R1: After reset the counter is 0, the update pulse and the flag are 0, the mode is down-counting, and the direction output is 1.
- R2: With `cnt_en` high, the divider produces one tick every divide+1 clocks. With `cnt_en` low, the counter and the divider both hold their values.
- R3: In down mode (control bit 1 = 0) each tick decrements the counter. A tick at 0 is an underflow. On an underflow the counter loads the new reload value when updates are enabled, and the current shadow value when they are disabled.
- R4: In center mode (control bit 1 = 1), going up, a tick at shadow−1 or above moves the counter to the shadow value, sets the direction, and signals an overflow. Going down, a tick at 1 or below moves it to 0, clears the direction, and signals an underflow. Every other tick steps the counter by one.
- R5: The direction output is 1 (down) in down mode. In center mode it follows the hardware-maintained direction.
- R6: When updates are enabled, every overflow and every underflow produces a one-clock `uev` pulse. The pulse shows in the same cycle as the counter's new value, and both shadow registers load from their preload registers.
- R7: Writes to the divide register (address 1) and the reload register (address 2) do not change counting until an update event transfers them.
- R8: While the update-disable bit (control bit 0) is 1, there are no update pulses, no shadow loads and no flag set. The counter keeps running on the shadow reload value.
- R9: Writing address 3 with bit 0 = 1 arms a one-clock strobe. At the following clock edge the counter, the divider and the direction restart from 0. The same edge raises an update event unless updates are disabled.
- R10: The flag `uif` is set by every update event and stays set. A write to address 3 with bit 1 = 0 clears it. A set in the same cycle wins over the clear.
- R11: A shadow reload value of 0 holds the counter at 0 and produces no overflow or underflow.
- R12: Register map: address 0 is control (bit 0 update-disable, bit 1 center mode), address 1 is the divide value, address 2 is the reload value, and address 3 is the event register. A write takes effect at the clock edge where `wr_en` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counter and divider enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | DATA_W | Register write data |
| count | output | CNT_W | Counter value |
| dir | output | 1 | Count direction, 1 = down |
| uev | output | 1 | Update event pulse |
| uif | output | 1 | Sticky update flag |

## Verification
The bench builds the block with its default 16-bit widths. It then programs divide values of 0 and 1 and reload values between 0 and 7, so that every overflow, underflow and reload boundary comes round within a few clocks. This keeps all turnarounds, the one-step reload of 1 and the stopped reload of 0 inside a run of a few hundred cycles. Runs with updates disabled, forced updates with updates both enabled and disabled, and enable gaps are compared every clock against a behavioural model.

// File: rtl/ctr_pkg.sv
`timescale 1ns/1ps
package ctr_pkg;
   typedef enum logic [1:0] {
      ADDR_CTRL = 2'd0,
      ADDR_DIV  = 2'd1,
      ADDR_RLD  = 2'd2,
      ADDR_EVT  = 2'd3
   } reg_addr_e;

   localparam int CTRL_UDIS_BIT   = 0;
   localparam int CTRL_CENTER_BIT = 1;
   localparam int EVT_STROBE_BIT  = 0;
   localparam int EVT_FLAG_BIT    = 1;
endpackage

// File: rtl/ctr_regs.sv
`timescale 1ns/1ps
module ctr_regs #(
   parameter int CNT_W  = 16,
   parameter int PSC_W  = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              udis,
   output logic              center,
   output logic [PSC_W-1:0]  div_pre,
   output logic [CNT_W-1:0]  rld_pre,
   output logic              ug_pend,
   output logic              flag_clr
);
   import ctr_pkg::*;

   logic wr_ctrl, wr_div, wr_rld, wr_evt;
   logic unused_upper;

   assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
   assign wr_div  = wr_en && (wr_addr == ADDR_DIV);
   assign wr_rld  = wr_en && (wr_addr == ADDR_RLD);
   assign wr_evt  = wr_en && (wr_addr == ADDR_EVT);

   assign flag_clr     = wr_evt && !wr_data[EVT_FLAG_BIT];
   assign unused_upper = ^wr_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         udis    <= 1'b0;
         center  <= 1'b0;
         div_pre <= '0;
         rld_pre <= '0;
         ug_pend <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            udis   <= wr_data[CTRL_UDIS_BIT];
            center <= wr_data[CTRL_CENTER_BIT];
         end
         if (wr_div) div_pre <= wr_data[PSC_W-1:0];
         if (wr_rld) rld_pre <= wr_data[CNT_W-1:0];
         ug_pend <= wr_evt && wr_data[EVT_STROBE_BIT];
      end
   end
endmodule

// File: rtl/ctr_divider.sv
`timescale 1ns/1ps
module ctr_divider #(
   parameter int PSC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic             load,
   input  logic [PSC_W-1:0] div_pre,
   output logic             tick
);
   logic [PSC_W-1:0] div_cnt;
   logic [PSC_W-1:0] div_sh;

   assign tick = run && !restart && (div_cnt == div_sh);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_cnt <= '0;
         div_sh  <= '0;
      end else begin
         if (restart)  div_cnt <= '0;
         else if (run) div_cnt <= tick ? '0 : div_cnt + PSC_W'(1);
         if (load)     div_sh  <= div_pre;
      end
   end
endmodule

// File: rtl/ctr_core.sv
`timescale 1ns/1ps
module ctr_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             restart,
   input  logic             center,
   input  logic             udis,
   input  logic [CNT_W-1:0] rld_pre,
   output logic [CNT_W-1:0] count,
   output logic             dir,
   output logic             upd_evt,
   output logic [CNT_W-1:0] rld_sh
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q, cnt_nxt;
   logic             dir_q, dir_nxt;
   logic             turn;

   always_comb begin
      cnt_nxt = cnt_q;
      dir_nxt = dir_q;
      turn    = 1'b0;
      if (rld_sh == '0) begin
         cnt_nxt = '0;
         dir_nxt = 1'b0;
      end else if (!center) begin
         if (cnt_q == '0) begin
            turn    = 1'b1;
            cnt_nxt = udis ? rld_sh : rld_pre;
         end else begin
            cnt_nxt = cnt_q - ONE;
         end
      end else if (!dir_q) begin
         if (cnt_q >= rld_sh - ONE) begin
            turn    = 1'b1;
            cnt_nxt = rld_sh;
            dir_nxt = 1'b1;
         end else begin
            cnt_nxt = cnt_q + ONE;
         end
      end else begin
         if (cnt_q <= ONE) begin
            turn    = 1'b1;
            cnt_nxt = '0;
            dir_nxt = 1'b0;
         end else begin
            cnt_nxt = cnt_q - ONE;
         end
      end
   end

   assign upd_evt = !udis && (restart || (tick && turn));
   assign count   = cnt_q;
   assign dir     = center ? dir_q : 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         dir_q  <= 1'b0;
         rld_sh <= '0;
      end else begin
         if (restart) begin
            cnt_q <= '0;
            dir_q <= 1'b0;
         end else if (tick) begin
            cnt_q <= cnt_nxt;
            dir_q <= dir_nxt;
         end
         if (upd_evt) rld_sh <= rld_pre;
      end
   end
endmodule

// File: rtl/ctr_center_timer.sv
`timescale 1ns/1ps
module ctr_center_timer #(
   parameter int CNT_W  = 16,
   parameter int PSC_W  = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_en,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [CNT_W-1:0]  count,
   output logic              dir,
   output logic              uev,
   output logic              uif
);
   generate
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt_w
         $error("CNT_W must lie between 2 and DATA_W");
      end
      if (PSC_W < 1 || PSC_W > DATA_W) begin : g_bad_psc_w
         $error("PSC_W must lie between 1 and DATA_W");
      end
      if (DATA_W < 2) begin : g_bad_data_w
         $error("DATA_W must hold the event register bits");
      end
   endgenerate

   logic             udis, center, ug_pend, flag_clr, tick, upd_evt;
   logic [PSC_W-1:0] div_pre;
   logic [CNT_W-1:0] rld_pre, arr_sh;

   ctr_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .udis(udis), .center(center), .div_pre(div_pre),
      .rld_pre(rld_pre), .ug_pend(ug_pend), .flag_clr(flag_clr)
   );

   ctr_divider #(.PSC_W(PSC_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(cnt_en), .restart(ug_pend),
      .load(upd_evt), .div_pre(div_pre), .tick(tick)
   );

   ctr_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick), .restart(ug_pend),
      .center(center), .udis(udis), .rld_pre(rld_pre), .count(count),
      .dir(dir), .upd_evt(upd_evt), .rld_sh(arr_sh)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         uev <= 1'b0;
         uif <= 1'b0;
      end else begin
         uev <= upd_evt;
         if (upd_evt)       uif <= 1'b1;
         else if (flag_clr) uif <= 1'b0;
      end
   end
endmodule

// File: rtl/ctr_center_timer_chk.sv
`timescale 1ns/1ps
module ctr_center_timer_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cnt_en,
   input logic             ug_pend,
   input logic             udis,
   input logic [CNT_W-1:0] count,
   input logic             uev,
   input logic             uif,
   input logic [CNT_W-1:0] arr_sh
);
   assert_flag_follows_update_R10: assert property (
      @(posedge clk) disable iff (!rst_n) uev |-> uif);

   assert_disabled_silent_R8: assert property (
      @(posedge clk) disable iff (!rst_n) $past(udis) |-> !uev);

   assert_hold_when_idle_R2: assert property (
      @(posedge clk) disable iff (!rst_n)
      $past(!cnt_en && !ug_pend) |-> $stable(count));

   assert_zero_reload_quiet_R11: assert property (
      @(posedge clk) disable iff (!rst_n)
      $past(arr_sh == '0 && !ug_pend) |-> !uev);
endmodule

bind ctr_center_timer ctr_center_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .ug_pend(ug_pend),
   .udis(udis), .count(count), .uev(uev), .uif(uif), .arr_sh(arr_sh)
);

// File: tb/sim_ctr_center_timer.sv
`timescale 1ns/1ps
module sim_ctr_center_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = 2'd0;
   logic [15:0] wr_data = 16'd0;
   logic [15:0] count;
   logic        dir, uev, uif;

   int  n_chk = 0, n_fail = 0, cyc = 0;
   bit  done = 1'b0;
   string cur_tag = "R1";

   always #4 clk = ~clk;

   ctr_center_timer u0 (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .count(count), .dir(dir),
      .uev(uev), .uif(uif)
   );

   // behavioural reference model
   int m_cnt, m_dq, m_pc, m_psh, m_ppre, m_ash, m_apre, nc, nd;
   bit m_udis, m_ctr, m_ug, m_uev, m_uif, tk, wrap, evt;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_dq = 0; m_pc = 0; m_psh = 0; m_ppre = 0;
         m_ash = 0; m_apre = 0; m_udis = 0; m_ctr = 0; m_ug = 0;
         m_uev = 0; m_uif = 0;
      end else begin
         tk = cnt_en && !m_ug && (m_pc == m_psh);
         wrap = 0; nc = m_cnt; nd = m_dq;
         if (m_ash == 0) begin nc = 0; nd = 0; end
         else if (!m_ctr) begin
            if (m_cnt == 0) begin wrap = 1; nc = m_udis ? m_ash : m_apre; end
            else nc = m_cnt - 1;
         end else if (m_dq == 0) begin
            if (m_cnt + 1 >= m_ash) begin wrap = 1; nc = m_ash; nd = 1; end
            else nc = m_cnt + 1;
         end else begin
            if (m_cnt <= 1) begin wrap = 1; nc = 0; nd = 0; end
            else nc = m_cnt - 1;
         end
         evt = !m_udis && (m_ug || (tk && wrap));
         if (m_ug) begin m_cnt = 0; m_dq = 0; m_pc = 0; end
         else begin
            if (tk) begin m_cnt = nc; m_dq = nd; end
            if (cnt_en) m_pc = tk ? 0 : m_pc + 1;
         end
         if (evt) begin m_ash = m_apre; m_psh = m_ppre; end
         if (evt) m_uif = 1;
         else if (wr_en && wr_addr == 2'd3 && !wr_data[1]) m_uif = 0;
         m_uev = evt;
         m_ug = wr_en && wr_addr == 2'd3 && wr_data[0];
         if (wr_en && wr_addr == 2'd0) begin m_udis = wr_data[0]; m_ctr = wr_data[1]; end
         if (wr_en && wr_addr == 2'd1) m_ppre = wr_data;
         if (wr_en && wr_addr == 2'd2) m_apre = wr_data;
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(cur_tag, int'(count), m_cnt);
         check("R5", int'(dir), m_ctr ? m_dq : 1);
         check("R6", int'(uev), int'(m_uev));
         check("R10", int'(uif), int'(m_uif));
      end
   end

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
         finish_run();
      end
   end

   int held;

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", int'(count), 0);
      check("R1", int'(uev), 0);
      check("R1", int'(uif), 0);
      check("R1", int'(dir), 1);

      // reload shadow 0: counter parked
      cnt_en = 1'b1; cur_tag = "R11";
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         check("R11", int'(count), 0);
         check("R11", int'(uev), 0);
      end

      // preloads wait for an update
      wr(2'd1, 16'd1); wr(2'd2, 16'd5); cur_tag = "R7";
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         check("R7", int'(count), 0);
      end

      // forced update loads shadows
      wr(2'd3, 16'd1);
      @(negedge clk);
      check("R9", int'(count), 0);
      check("R9", int'(uev), 1);
      cur_tag = "R3";
      idle(40);
      wr(2'd2, 16'd3); cur_tag = "R7";
      idle(30);

      // clear flag while stopped
      cnt_en = 1'b0;
      idle(2);
      wr(2'd3, 16'd0);
      check("R10", int'(uif), 0);

      // updates disabled
      wr(2'd0, 16'd1); wr(2'd2, 16'd7); cnt_en = 1'b1; cur_tag = "R8";
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         check("R8", int'(uev), 0);
      end
      check("R8", int'(uif), 0);

      // center mode, updates enabled
      wr(2'd0, 16'd2);
      wr(2'd3, 16'd1);
      @(negedge clk);
      check("R9", int'(count), 0);
      check("R9", int'(uev), 1);
      check("R12", int'(dir), 0);
      cur_tag = "R4";
      idle(60);

      // one-step reload, undivided clock
      wr(2'd2, 16'd1); wr(2'd1, 16'd0); wr(2'd3, 16'd1);
      idle(20);

      // enable gap
      cur_tag = "R2";
      @(negedge clk);
      cnt_en = 1'b0; held = int'(count);
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         check("R2", int'(count), held);
      end
      cnt_en = 1'b1;
      idle(10);

      // forced update with updates disabled
      wr(2'd2, 16'd4); wr(2'd0, 16'd3);
      wr(2'd3, 16'd1);
      @(negedge clk);
      check("R9", int'(count), 0);
      check("R9", int'(uev), 0);
      cur_tag = "R8";
      idle(20);

      // reload 0 transferred at the next turnaround
      wr(2'd0, 16'd2); wr(2'd2, 16'd0); cur_tag = "R11";
      idle(30);
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         check("R11", int'(count), 0);
         check("R11", int'(uev), 0);
      end
      finish_run();
   end
endmodule